// File: doc/BRIEF.md
# Fractional Feedback Clock Divider

This block divides a fast input clock down to a reference-rate pulse for a digital frequency-multiplying loop. A programmed ratio sets the length of each output period in input cycles. The ratio has two parts. The integer part is the integer field plus one. The fractional part is the fraction field counted in sixteenths.

A 4-bit phase accumulator adds the fraction field once per output period. On each carry-out of the accumulator, that period is stretched by one input cycle. Over sixteen periods, the average period therefore equals the fractional ratio. A fraction of zero gives plain integer division, and the mode flag reports which mode the current period uses. Both fields are captured only when a period begins. Dropping the enable returns the block to its idle reset state.

The control is a two-state machine:
- `FD_IDLE`: disabled. Counter, accumulator and flag are cleared, and no pulse is produced.
- `FD_RUN`: counting.

It has three transitions:
- `IDLE->RUN`: enable seen. This starts the first period.
- `RUN->RUN`: counting. This includes the reload at the period's last cycle.
- `RUN->IDLE`: enable dropped.

Top module: `fdiv_top`

## Requirements
- R1: Each output period lasts (integer field + 1 + c) input cycles, where c is the accumulator carry (0 or 1) for that period. The first pulse after enable comes on the (integer field + 1)-th clock edge in `FD_RUN`.
- R2: With the fraction field at 0, every period is exactly integer field + 1 cycles, and the mode flag is 0.
- R3: With a nonzero fraction field, the mode flag is 1 for the periods that sampled it.
- R4: An integer field of 1499 with fraction 0 gives periods of exactly 1500 cycles.
- R5: An integer field of 1499 with fraction 3 gives 24003 cycles over 16 consecutive periods, which is an average of 1500 + 3/16.
- R6: With a constant fraction field f, any 16 consecutive periods contain exactly f lengthened periods.
- R7: The integer and fraction fields are sampled only at the start of a period. A change in mid-period does not alter the running period.
- R8: The output pulse is one input cycle wide whenever the integer field is nonzero.
- R9: While the enable is low, the pulse and the mode flag stay 0. On re-enable, the accumulator restarts from zero.
- R10: During reset, the pulse and the mode flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Divider enable; low holds the block idle |
| int_div | input | INT_W | Integer field; base period is int_div + 1 |
| frac_div | input | FRAC_W | Fraction field in sixteenths |
| pulse_o | output | 1 | One-cycle divided output pulse |
| frac_mode_o | output | 1 | 1 when the current period runs in fractional mode |

## Verification
The assertions check four things on every cycle:
- the idle behaviour after the enable drops;
- the single-cycle width of the pulse;
- that the mode flag follows the fraction field sampled at each period boundary;
- that a pulse only ever comes from the counting state.

The bench's scenarios are needed for the behaviour that only shows across many periods:
- the exact period lengths;
- the count of lengthened periods over sixteen-period windows;
- the 1500 and 1500 + 3/16 ratios;
- immunity to mid-period field changes;
- the restart of the accumulator after re-enable.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
    typedef enum logic [0:0] {
        FD_IDLE = 1'b0,
        FD_RUN  = 1'b1
    } fd_state_t;
endpackage

// File: rtl/fdiv_phase_acc.sv
module fdiv_phase_acc #(
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    input  logic [FRAC_W-1:0] frac_in,
    output logic              carry_o
);
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;

    always_comb begin
        sum     = {1'b0, acc_q} + {1'b0, frac_in};
        carry_o = sum[FRAC_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc_q <= '0;
        else if (clr)
            acc_q <= '0;
        else if (step)
            acc_q <= sum[FRAC_W-1:0];
    end
endmodule

// File: rtl/fdiv_period_cnt.sv
module fdiv_period_cnt #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fdiv_top.sv
module fdiv_top #(
    parameter int INT_W  = 12,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [INT_W-1:0]  int_div,
    input  logic [FRAC_W-1:0] frac_div,
    output logic              pulse_o,
    output logic              frac_mode_o
);
    import fdiv_pkg::*;

    localparam int CNT_W = INT_W + 1;

    fd_state_t        state_q, state_d;
    logic             cnt_zero;
    logic             carry;
    logic             period_start;
    logic             clr;
    logic [CNT_W-1:0] load_val;
    logic             mode_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= FD_IDLE;
        else
            state_q <= state_d;
    end

    // Next state and period boundary
    always_comb begin
        state_d      = state_q;
        period_start = 1'b0;
        unique case (state_q)
            FD_IDLE: begin
                if (en) begin
                    state_d      = FD_RUN;
                    period_start = 1'b1;
                end
            end
            FD_RUN: begin
                if (!en)
                    state_d = FD_IDLE;
                else if (cnt_zero)
                    period_start = 1'b1;
            end
            default: state_d = FD_IDLE;
        endcase
    end

    assign clr      = !en;
    assign load_val = {1'b0, int_div} + {{(CNT_W-1){1'b0}}, carry};

    fdiv_phase_acc #(.FRAC_W(FRAC_W)) acc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .step    (period_start),
        .frac_in (frac_div),
        .carry_o (carry)
    );

    fdiv_period_cnt #(.CNT_W(CNT_W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .load     (period_start),
        .load_val (load_val),
        .zero_o   (cnt_zero)
    );

    // Mode flag captured with each period's fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode_q <= 1'b0;
        else if (clr)
            mode_q <= 1'b0;
        else if (period_start)
            mode_q <= (frac_div != '0);
    end

    // Outputs
    always_comb begin
        pulse_o     = 1'b0;
        frac_mode_o = mode_q;
        unique case (state_q)
            FD_IDLE: pulse_o = 1'b0;
            FD_RUN:  pulse_o = cnt_zero;
            default: pulse_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/fdiv_checker.sv
module fdiv_checker #(
    parameter int INT_W  = 12,
    parameter int FRAC_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [INT_W-1:0]  int_div,
    input logic [FRAC_W-1:0] frac_div,
    input logic              pulse_o,
    input logic              frac_mode_o,
    input logic              state_q
);
    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!pulse_o && !frac_mode_o));

    // R8
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o && en && int_div != '0) |=> !pulse_o);

    // R3
    frac_mode_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o && en && frac_div != '0) |=> frac_mode_o);

    // R2
    int_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o && en && frac_div == '0) |=> !frac_mode_o);

    // R9
    pulse_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> state_q);
endmodule

bind fdiv_top fdiv_checker #(.INT_W(INT_W), .FRAC_W(FRAC_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .int_div     (int_div),
    .frac_div    (frac_div),
    .pulse_o     (pulse_o),
    .frac_mode_o (frac_mode_o),
    .state_q     (state_q)
);

// File: tb/fdiv_top_tb_top.sv
`timescale 1ns/1ps
module fdiv_top_tb_top;
    localparam int INT_W  = 12;
    localparam int FRAC_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b0;
    logic [INT_W-1:0]  int_div = '0;
    logic [FRAC_W-1:0] frac_div = '0;
    logic              pulse_o;
    logic              frac_mode_o;

    int checks = 0;
    int errors = 0;

    // reference model state
    bit m_run  = 0;
    int m_left = 0;
    int m_acc  = 0;
    bit m_mode = 0;

    always #5 clk = ~clk;

    fdiv_top #(.INT_W(INT_W), .FRAC_W(FRAC_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .int_div(int_div),
        .frac_div(frac_div), .pulse_o(pulse_o), .frac_mode_o(frac_mode_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural model: remaining cycles in the period, phase sum in sixteenths
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 0; m_left = 0; m_acc = 0; m_mode = 0;
        end else if (!en) begin
            m_run = 0; m_left = 0; m_acc = 0; m_mode = 0;
        end else if (!m_run || m_left == 0) begin
            int s;
            s      = m_acc + int'(frac_div);
            m_acc  = s % 16;
            m_left = int'(int_div) + ((s >= 16) ? 1 : 0);
            m_run  = 1;
            m_mode = (frac_div != 0);
        end else begin
            m_left = m_left - 1;
        end
    end

    // per-cycle comparison (R1, R3)
    always @(negedge clk) begin
        if (rst_n) begin
            check("R1 model pulse", int'(pulse_o), int'(m_run && m_left == 0));
            check("R3 model mode", int'(frac_mode_o), int'(m_mode));
        end
    end

    task automatic wait_pulse();
        do @(negedge clk); while (!pulse_o);
    endtask

    // cycles spanned by n periods, starting at a pulse
    task automatic span(input int n, output int cyc);
        cyc = 0;
        for (int i = 0; i < n; i++) begin
            do begin @(negedge clk); cyc++; end while (!pulse_o);
        end
    endtask

    initial begin
        int c;
        int first;
        #200000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int c;
        int first;
        // R10 reset state
        repeat (3) @(negedge clk);
        check("R10 pulse in reset", int'(pulse_o), 0);
        check("R10 mode in reset", int'(frac_mode_o), 0);
        rst_n = 1'b1;

        // R1 first pulse timing and R2 integer periods
        @(negedge clk); int_div = 4; frac_div = 0; en = 1;
        first = 0;
        do begin @(negedge clk); first++; end while (!pulse_o);
        check("R1 first pulse", first, 5);
        for (int k = 0; k < 3; k++) begin
            span(1, c);
            check("R2 integer period", c, 5);
        end
        check("R2 mode flag", int'(frac_mode_o), 0);

        // R6 fraction 5: two different 16-period windows
        @(negedge clk); frac_div = 5;
        wait_pulse(); wait_pulse();
        check("R3 mode flag", int'(frac_mode_o), 1);
        span(16, c); check("R6 window A", c, 16*5 + 5);
        span(3, c);
        span(16, c); check("R6 window B", c, 16*5 + 5);

        // R7 mid-period change
        @(negedge clk); int_div = 9; frac_div = 0;
        wait_pulse(); wait_pulse();
        c = 0;
        repeat (3) begin @(negedge clk); c++; end
        int_div = 2;
        while (!pulse_o) begin @(negedge clk); c++; end
        check("R7 running period kept", c, 10);
        span(1, c); check("R7 new period", c, 3);

        // R9 disable
        @(negedge clk); en = 0; frac_div = 7;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            check("R9 pulse idle", int'(pulse_o), 0);
            check("R9 mode idle", int'(frac_mode_o), 0);
        end
        // re-enable: acc restarts, 7 does not carry on first period
        int_div = 4; en = 1;
        first = 0;
        do begin @(negedge clk); first++; end while (!pulse_o);
        check("R9 restart first period", first, 5);

        // R4 1500 exact
        @(negedge clk); int_div = 1499; frac_div = 0;
        wait_pulse();
        for (int k = 0; k < 2; k++) begin
            span(1, c); check("R4 period 1500", c, 1500);
        end

        // R5 1500 + 3/16
        @(negedge clk); frac_div = 3;
        wait_pulse();
        span(16, c); check("R5 sixteen periods", c, 16*1500 + 3);

        // R8 single-cycle pulse
        @(negedge clk); int_div = 1; frac_div = 0;
        wait_pulse();
        @(negedge clk); check("R8 pulse width", int'(pulse_o), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule